// File: doc/BRIEF.md
# Sequenced Decimal Digit Adder

This block adds two decimal digits held in a small register file. Each digit is stored as a 4-bit binary-coded value. The block has no dedicated decimal adder. A single 4-bit binary adder is used twice per operation, under a short fixed sequence:

1. The two source entries are copied into operand registers.
2. Their binary sum and carry are captured.
3. The carry is moved into a status flag, and a correction decision is made.
4. The temporary sum is passed back through the same adder together with either 0110 or 0000.
5. The corrected digit is written to the destination entry.

The caller loads digits through an initialisation write port while the block is idle. It then pulses `start_i` with two source indices and one destination index. The caller waits for the one-cycle `done_o` pulse and then reads the decimal carry on `carry_o`. A separate read port shows any register-file entry at any time.

All pins are plain control or data pins. There is no valid/ready stream interface, so there is no back-pressure. A start that arrives while the block is busy is dropped, not queued. An initialisation write that arrives while the block is busy is also dropped.

Top module: `bcd_seq_adder`

## Requirements
- R1: While `rst_n` is low and after reset, `busy_o`, `done_o` and `carry_o` are 0, and every register-file entry reads 0000.
- R2: When the block is idle, `init_we_i` writes `init_data_i` into entry `init_addr_i`. The new value appears on `obs_data_o` after that clock edge.
- R3: An `init_we_i` write that arrives while `busy_o` is 1 leaves every entry unchanged.
- R4: A start accepted at clock edge E0 drives `busy_o` high for exactly five cycles. The destination entry is written at edge E5. `done_o` is 1 only in the cycle that follows E5, and `busy_o` is 0 in that same cycle.
- R5: A `start_i` that arrives while `busy_o` is 1 has no effect. The running operation keeps its operands and destination, and no second operation follows it.
- R6: The destination receives a+b when a+b is 9 or less. It receives a+b-10 when a+b is 10 or more. In the second case the first binary sum is corrected by adding 0110 and keeping the low 4 bits.
- R7: `carry_o` becomes 1 at the write-back edge when a+b is 10 or more, and 0 otherwise. It keeps that value until the next start is accepted, and that start clears it to 0.
- R8: The source entries are read one cycle after the start is accepted. An initialisation write made in the same cycle as the start is therefore seen as an operand.
- R9: The destination may be the same entry as a source. Only the destination entry changes.
- R10: The correction constant used in the second pass is 0110 when the first pass gave a carry out or a sum of 1010 or more. Otherwise it is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one digit addition; accepted only when idle |
| src_a_i | input | 3 | Index of the first source entry |
| src_b_i | input | 3 | Index of the second source entry |
| dst_i | input | 3 | Index of the destination entry |
| init_we_i | input | 1 | Initialisation write enable; used only when idle |
| init_addr_i | input | 3 | Initialisation write index |
| init_data_i | input | 4 | Initialisation write digit |
| obs_addr_i | input | 3 | Index for the observation read port |
| obs_data_o | output | 4 | Contents of entry `obs_addr_i` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after write-back |
| carry_o | output | 1 | Decimal carry of the last completed addition |

## Verification
Two functions can meet in one cycle: an initialisation write and a start. The bench provokes this in two ways. First, it issues a start while writing a new digit into a source entry at the same edge. The expected sum must use the new digit. Second, it issues starts and writes while the block is busy, and also in the same cycle that `done_o` is high. A start in the `done_o` cycle must be accepted, because the block is idle again. A reference model advances every clock and is compared with `busy_o`, `done_o`, `carry_o` and a sweeping observation read on every cycle, so that any write landing in the wrong cycle shows up at once.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W  = 4;
  localparam int RADIX    = 10;
  localparam int CORR_VAL = (1 << DIGIT_W) - RADIX;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_ADD1  = 3'd2,
    ST_FLAG  = 3'd3,
    ST_ADD2  = 3'd4,
    ST_WRITE = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    MB_OPB  = 2'd0,
    MB_ZERO = 2'd1,
    MB_CORR = 2'd2
  } mux_b_sel_t;

  typedef enum logic {
    MA_OPA = 1'b0,
    MA_TMP = 1'b1
  } mux_a_sel_t;
endpackage

// File: rtl/bcd_regfile.sv
module bcd_regfile #(
  parameter int DEPTH = 8,
  parameter int DW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  input  logic [AW-1:0] raddr_o,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                           mem[g] <= '0;
      else if (we && (waddr == AW'(g)))     mem[g] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
  assign rdata_o = mem[raddr_o];
endmodule

// File: rtl/bcd_nibble_alu.sv
module bcd_nibble_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end
  assign cout = c[W];
endmodule

// File: rtl/bcd_fix_detect.sv
module bcd_fix_detect #(
  parameter int W     = 4,
  parameter int RADIX = 10
) (
  input  logic [W-1:0] first_sum,
  input  logic         first_carry,
  output logic         fix
);
  localparam logic [W-1:0] LIMIT = W'(RADIX);
  assign fix = first_carry | (first_sum >= LIMIT);
endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       fix_q,
  output seq_state_t state,
  output logic       accept,
  output logic       load_en,
  output logic       add1_en,
  output logic       flag_en,
  output logic       add2_en,
  output logic       wb_en,
  output mux_a_sel_t mux_a_sel,
  output mux_b_sel_t mux_b_sel,
  output logic       busy,
  output logic       done
);
  seq_state_t nxt;
  logic       done_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start_i) nxt = ST_LOAD;
      ST_LOAD:  nxt = ST_ADD1;
      ST_ADD1:  nxt = ST_FLAG;
      ST_FLAG:  nxt = ST_ADD2;
      ST_ADD2:  nxt = ST_WRITE;
      ST_WRITE: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= (state == ST_WRITE);
    end
  end

  assign accept    = (state == ST_IDLE) && start_i;
  assign load_en   = (state == ST_LOAD);
  assign add1_en   = (state == ST_ADD1);
  assign flag_en   = (state == ST_FLAG);
  assign add2_en   = (state == ST_ADD2);
  assign wb_en     = (state == ST_WRITE);
  assign mux_a_sel = (state == ST_ADD2) ? MA_TMP : MA_OPA;
  assign mux_b_sel = (state != ST_ADD2) ? MB_OPB : (fix_q ? MB_CORR : MB_ZERO);
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> busy);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/bcd_seq_adder.sv
module bcd_seq_adder
  import bcd_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = DIGIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_a_i,
  input  logic [AW-1:0] src_b_i,
  input  logic [AW-1:0] dst_i,
  input  logic          init_we_i,
  input  logic [AW-1:0] init_addr_i,
  input  logic [DW-1:0] init_data_i,
  input  logic [AW-1:0] obs_addr_i,
  output logic [DW-1:0] obs_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          carry_o
);
  localparam logic [DW-1:0] CORR = DW'(CORR_VAL);

  seq_state_t    state;
  mux_a_sel_t    mux_a_sel;
  mux_b_sel_t    mux_b_sel;
  logic          accept, load_en, add1_en, flag_en, add2_en, wb_en;
  logic          busy, done;
  logic [AW-1:0] src_a_q, src_b_q, dst_q;
  logic [DW-1:0] opa_q, opb_q, sum_q;
  logic          c1_q, flag_q, fix_q, carry_q, fix_c;
  logic [DW-1:0] alu_a, alu_b, alu_sum;
  logic          alu_cout;
  logic [DW-1:0] rd_a, rd_b;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  bcd_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fix_q(fix_q),
    .state(state), .accept(accept), .load_en(load_en), .add1_en(add1_en),
    .flag_en(flag_en), .add2_en(add2_en), .wb_en(wb_en),
    .mux_a_sel(mux_a_sel), .mux_b_sel(mux_b_sel), .busy(busy), .done(done)
  );

  assign rf_we    = wb_en | (init_we_i & ~busy);
  assign rf_waddr = wb_en ? dst_q : init_addr_i;
  assign rf_wdata = wb_en ? sum_q : init_data_i;

  bcd_regfile #(.DEPTH(DEPTH), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(src_a_q), .raddr_b(src_b_q), .raddr_o(obs_addr_i),
    .rdata_a(rd_a), .rdata_b(rd_b), .rdata_o(obs_data_o)
  );

  always_comb begin
    alu_a = (mux_a_sel == MA_TMP) ? sum_q : opa_q;
    unique case (mux_b_sel)
      MB_OPB:  alu_b = opb_q;
      MB_ZERO: alu_b = '0;
      MB_CORR: alu_b = CORR;
      default: alu_b = '0;
    endcase
  end

  bcd_nibble_alu #(.W(DW)) u_alu (
    .a(alu_a), .b(alu_b), .cin(1'b0), .sum(alu_sum), .cout(alu_cout)
  );

  bcd_fix_detect #(.W(DW), .RADIX(RADIX)) u_fix (
    .first_sum(sum_q), .first_carry(c1_q), .fix(fix_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_a_q <= '0; src_b_q <= '0; dst_q <= '0;
      opa_q   <= '0; opb_q   <= '0; sum_q <= '0;
      c1_q    <= 1'b0; flag_q <= 1'b0; fix_q <= 1'b0; carry_q <= 1'b0;
    end else begin
      if (accept) begin
        src_a_q <= src_a_i;
        src_b_q <= src_b_i;
        dst_q   <= dst_i;
        carry_q <= 1'b0;
      end
      if (load_en) begin
        opa_q <= rd_a;
        opb_q <= rd_b;
      end
      if (add1_en) begin
        sum_q <= alu_sum;
        c1_q  <= alu_cout;
      end
      if (flag_en) begin
        flag_q <= c1_q;
        fix_q  <= fix_c;
      end
      if (add2_en) sum_q <= alu_sum;
      if (wb_en)   carry_q <= flag_q | fix_q;
    end
  end

  assign busy_o  = busy;
  assign done_o  = done;
  assign carry_o = carry_q;

  p_corr_pick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD2) |-> (alu_b == (fix_q ? CORR : '0)));
  p_fix_on_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && c1_q) |=> fix_q);
  p_busy_no_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && busy) |-> (state == ST_WRITE));
  p_carry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_en && !accept) |=> $stable(carry_o));
  p_busy_start_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(dst_q));
endmodule

// File: tb/bcd_seq_adder_tb_top.sv
module bcd_seq_adder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic       init_we_i = 1'b0;
  logic [2:0] init_addr_i = '0;
  logic [3:0] init_data_i = '0;
  logic [2:0] obs_addr_i = '0;
  logic [3:0] obs_data_o;
  logic       busy_o, done_o, carry_o;

  always #5 clk = ~clk;

  bcd_seq_adder dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .dst_i(dst_i), .init_we_i(init_we_i),
    .init_addr_i(init_addr_i), .init_data_i(init_data_i),
    .obs_addr_i(obs_addr_i), .obs_data_o(obs_data_o), .busy_o(busy_o),
    .done_o(done_o), .carry_o(carry_o)
  );

  int    vectors = 0;
  int    errors  = 0;
  bit    finished = 1'b0;
  string phase = "R1";

  int m_rf [8];
  int m_cnt, m_a, m_b, m_sa, m_sb, m_d;
  bit m_done, m_carry;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_rf[i] = 0;
      m_cnt = 0; m_done = 0; m_carry = 0;
      m_a = 0; m_b = 0; m_sa = 0; m_sb = 0; m_d = 0;
    end else begin
      m_done = 0;
      if (m_cnt == 0) begin
        if (init_we_i) m_rf[init_addr_i] = init_data_i;
        if (start_i) begin
          m_cnt = 1; m_carry = 0;
          m_sa = src_a_i; m_sb = src_b_i; m_d = dst_i;
        end
      end else if (m_cnt == 1) begin
        m_a = m_rf[m_sa]; m_b = m_rf[m_sb]; m_cnt = 2;
      end else if (m_cnt < 5) begin
        m_cnt = m_cnt + 1;
      end else begin
        if (m_a + m_b >= 10) begin m_rf[m_d] = m_a + m_b - 10; m_carry = 1; end
        else begin m_rf[m_d] = m_a + m_b; m_carry = 0; end
        m_done = 1; m_cnt = 0;
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("R4 busy", busy_o, (m_cnt != 0));
      cmp("R4 done", done_o, m_done);
      cmp("R7 carry", carry_o, m_carry);
      cmp("R6 entry", obs_data_o, m_rf[obs_addr_i]);
    end
  end

  always @(posedge clk) obs_addr_i <= obs_addr_i + 3'd1;

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic init(int a, int d);
    init_we_i = 1; init_addr_i = 3'(a); init_data_i = 4'(d);
    tick(); init_we_i = 0;
  endtask

  task automatic go(int a, int b, int d);
    start_i = 1; src_a_i = 3'(a); src_b_i = 3'(b); dst_i = 3'(d);
    tick(); start_i = 0;
  endtask

  task automatic wait_idle();
    while (busy_o || done_o) tick();
    repeat (8) tick();
  endtask

  task automatic add_case(int x, int y);
    init(0, x); init(1, y); go(0, 1, 2); wait_idle();
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (3) tick();          // R1: reset values compared every cycle
    rst_n = 1; repeat (8) tick();
    phase = "R2";
    for (int i = 0; i < 8; i++) init(i, (i * 3) % 10);
    repeat (8) tick();
    phase = "R6";
    add_case(3, 4); add_case(0, 0); add_case(9, 0); add_case(4, 5);
    phase = "R7";
    add_case(5, 5); add_case(9, 9); add_case(7, 8); add_case(1, 2);
    phase = "R5";               // start while busy is dropped
    init(3, 6); init(4, 7);
    go(3, 4, 5); tick(); go(0, 0, 6); go(1, 1, 7); wait_idle();
    phase = "R3";               // init write while busy is dropped
    go(3, 4, 6); init(7, 9); init(3, 1); wait_idle();
    phase = "R8";               // init and start in the same cycle
    init_we_i = 1; init_addr_i = 3'd0; init_data_i = 4'd8;
    go(0, 4, 1); init_we_i = 0; wait_idle();
    phase = "R9";               // destination equals a source
    go(4, 4, 4); wait_idle();
    phase = "R4";               // start in the done cycle is accepted
    go(3, 3, 2);
    while (!done_o) tick();
    go(2, 3, 5); wait_idle();
    phase = "R10";
    add_case(8, 8); add_case(6, 4); add_case(2, 7);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (%s) actual=timeout expected=finish", phase);
    finish_run();
  end
endmodule